// File: doc/BRIEF.md
# Domain-Tagged MAC Input Sequencer

This block assembles the byte stream that a byte-wide hash core consumes when it computes a message authentication code. Each operation is launched by a single start command. The command carries four things: an operation code, a word address into a 16-bit memory, a byte length, and four 16-bit module layout words. The block first emits a one-byte domain tag that keeps the operations apart. It then reads the memory region one word at a time and serializes each word into two bytes. An 8-bit holding register bridges the 16-bit read port and the 8-bit stream.

Two of the four operations also append the module layout after the memory bytes. These are module-key derivation and attestation/verification, and they bind the hashed identity to where the module sits in memory. The output uses a valid/ready handshake and tolerates any pattern of backpressure. A one-cycle done pulse marks the end of each operation. The hash core and the key storage sit outside this block.

Top module: `mac_feed_seq`

## Requirements
- R1: The first byte of every operation is the domain tag. Operation codes map to tags as follows: 0 (provider-key derivation) gives 0x01, 1 (module-key derivation) gives 0x02, 2 (attestation/verification) gives 0x03, and 3 (data seal) gives 0x04.
- R2: After the tag, memory bytes are emitted from word address start_addr upward. Word addresses increase by one and wrap at 2^AW. Each word is sent as bits [7:0] first and bits [15:8] second.
- R3: start_len counts bytes. An odd length sends only bits [7:0] of the final word. A length of zero sends no memory bytes.
- R4: For operation codes 1 and 2, eight layout bytes follow the memory bytes. The words go in the order text start, text end, protected start, protected end, and each word is sent low byte first.
- R5: Operation codes 0 and 3 send no layout bytes, so the stream is exactly 1 + start_len bytes.
- R6: hb_last is high on the final byte of an operation and low on every other byte.
- R7: While hb_valid is high and hb_ready is low, hb_valid stays high and hb_data and hb_last stay unchanged. No byte is dropped or repeated.
- R8: done is high for exactly one cycle: the cycle right after the edge at which the byte flagged hb_last is accepted.
- R9: A start command is accepted only while busy is low. busy rises in the cycle after acceptance. A start_valid seen while busy has no effect on the stream.
- R10: After reset, busy, done, hb_valid and mem_rd_en are low.
- R11: The memory port is word addressed. mem_rd_data is taken in the cycle after a cycle with mem_rd_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start command strobe |
| start_op | input | 2 | Operation code (see R1) |
| start_addr | input | AW | First word address |
| start_len | input | LW | Length in bytes |
| lay_text_lo | input | 16 | Text section start |
| lay_text_hi | input | 16 | Text section end |
| lay_prot_lo | input | 16 | Protected section start |
| lay_prot_hi | input | 16 | Protected section end |
| busy | output | 1 | Operation in progress |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rd_data | input | 16 | Read data, one cycle after request |
| hb_data | output | 8 | Byte to hash core |
| hb_valid | output | 1 | Byte valid |
| hb_ready | input | 1 | Hash core accepts byte |
| hb_last | output | 1 | Final byte of operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with AW=6 and LW=8. The 64-word memory is therefore small enough that a run of 255 bytes wraps the word address. This puts the maximum byte count and address wraparound within reach in one directed test. The bench covers odd, even and zero lengths for all four operation codes, with the hash input either always ready or stalled by a pseudo-random pattern. It also issues a second start command in the middle of an operation.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic [1:0] {
    OP_PROV_KEY  = 2'd0,
    OP_MOD_KEY   = 2'd1,
    OP_ATTEST    = 2'd2,
    OP_DATA_SEAL = 2'd3
  } mfs_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TAG, S_READ, S_SPLIT, S_HIGH, S_LAYOUT, S_FINISH
  } mfs_state_e;

  typedef enum logic [1:0] {
    SEL_TAG, SEL_LOW, SEL_HIGH, SEL_LAY
  } mfs_sel_e;

  localparam int LAYOUT_WORDS = 4;
  localparam int LAYOUT_BYTES = 2 * LAYOUT_WORDS;

  function automatic logic [7:0] tag_of(mfs_op_e op);
    return {6'd0, op} + 8'd1;
  endfunction

  function automatic logic wants_layout(mfs_op_e op);
    return (op == OP_MOD_KEY) || (op == OP_ATTEST);
  endfunction
endpackage

// File: rtl/mfs_out_stage.sv
module mfs_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_last,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         last,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      last  <= load_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mfs_word_split.sv
module mfs_word_split #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic [WORD_W-1:0]   word_in,
  output logic [WORD_W/2-1:0] low_byte,
  output logic [WORD_W/2-1:0] held_byte
);
  localparam int BW = WORD_W / 2;

  assign low_byte = word_in[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst)          held_byte <= '0;
    else if (capture) held_byte <= word_in[WORD_W-1:BW];
  end
endmodule

// File: rtl/mfs_ctrl.sv
module mfs_ctrl
  import mfs_pkg::*;
#(
  parameter int AW = 6,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  input  logic [1:0]    start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          slot_free,
  input  logic          out_taken,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  output logic          load,
  output mfs_sel_e      load_sel,
  output logic          load_last,
  output logic          capture,
  output logic [2:0]    lay_idx,
  output logic [7:0]    tag_byte
);
  localparam logic [LW-1:0] ONE = LW'(1);
  localparam logic [2:0]    LAST_IDX = 3'(LAYOUT_BYTES - 1);

  mfs_state_e    state_q, state_d;
  mfs_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [2:0]    idx_q;
  logic          done_q;
  logic          lay_q;
  logic          rem_dec, addr_inc, idx_inc;

  assign lay_q    = wants_layout(op_q);
  assign accept   = (state_q == S_IDLE) && start_valid;
  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign mem_addr = addr_q;
  assign lay_idx  = idx_q;
  assign tag_byte = tag_of(op_q);

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_sel  = SEL_TAG;
    load_last = 1'b0;
    capture   = 1'b0;
    mem_rd_en = 1'b0;
    rem_dec   = 1'b0;
    addr_inc  = 1'b0;
    idx_inc   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_valid) state_d = S_TAG;
      S_TAG: if (slot_free) begin
        load      = 1'b1;
        load_sel  = SEL_TAG;
        load_last = (rem_q == '0) && !lay_q;
        if (rem_q != '0) state_d = S_READ;
        else if (lay_q)  state_d = S_LAYOUT;
        else             state_d = S_FINISH;
      end
      S_READ: begin
        mem_rd_en = slot_free;
        if (slot_free) state_d = S_SPLIT;
      end
      S_SPLIT: begin
        load      = 1'b1;
        load_sel  = SEL_LOW;
        capture   = 1'b1;
        rem_dec   = 1'b1;
        load_last = (rem_q == ONE) && !lay_q;
        if (rem_q != ONE) state_d = S_HIGH;
        else if (lay_q)   state_d = S_LAYOUT;
        else              state_d = S_FINISH;
      end
      S_HIGH: if (slot_free) begin
        load      = 1'b1;
        load_sel  = SEL_HIGH;
        rem_dec   = 1'b1;
        addr_inc  = 1'b1;
        load_last = (rem_q == ONE) && !lay_q;
        if (rem_q != ONE) state_d = S_READ;
        else if (lay_q)   state_d = S_LAYOUT;
        else              state_d = S_FINISH;
      end
      S_LAYOUT: if (slot_free) begin
        load      = 1'b1;
        load_sel  = SEL_LAY;
        idx_inc   = 1'b1;
        load_last = (idx_q == LAST_IDX);
        if (idx_q == LAST_IDX) state_d = S_FINISH;
      end
      S_FINISH: if (out_taken) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROV_KEY;
      addr_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_FINISH) && out_taken;
      if (accept) begin
        op_q   <= mfs_op_e'(start_op);
        addr_q <= start_addr;
        rem_q  <= start_len;
        idx_q  <= '0;
      end else begin
        if (rem_dec)  rem_q  <= rem_q - ONE;
        if (addr_inc) addr_q <= addr_q + AW'(1);
        if (idx_inc)  idx_q  <= idx_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/mac_feed_seq.sv
module mac_feed_seq
  import mfs_pkg::*;
#(
  parameter int AW = 6,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  input  logic [1:0]    start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic [15:0]   lay_text_lo,
  input  logic [15:0]   lay_text_hi,
  input  logic [15:0]   lay_prot_lo,
  input  logic [15:0]   lay_prot_hi,
  output logic          busy,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rd_data,
  output logic [7:0]    hb_data,
  output logic          hb_valid,
  input  logic          hb_ready,
  output logic          hb_last,
  output logic          done
);
  logic [LAYOUT_WORDS-1:0][15:0] lay_q;
  logic [7:0] lay_byte [LAYOUT_BYTES];
  logic       accept, slot_free, load, load_last, capture;
  mfs_sel_e   load_sel;
  logic [2:0] lay_idx;
  logic [7:0] tag_byte, low_byte, held_byte, load_data;

  always_ff @(posedge clk) begin
    if (rst)         lay_q <= '0;
    else if (accept) lay_q <= {lay_prot_hi, lay_prot_lo, lay_text_hi, lay_text_lo};
  end

  for (genvar g = 0; g < LAYOUT_BYTES; g++) begin : g_lay
    assign lay_byte[g] = lay_q[g/2][(g%2)*8 +: 8];
  end

  mfs_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_op(start_op),
    .start_addr(start_addr), .start_len(start_len),
    .slot_free(slot_free), .out_taken(hb_valid && hb_ready),
    .accept(accept), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .load(load), .load_sel(load_sel), .load_last(load_last),
    .capture(capture), .lay_idx(lay_idx), .tag_byte(tag_byte)
  );

  mfs_word_split #(.WORD_W(16)) u_split (
    .clk(clk), .rst(rst), .capture(capture), .word_in(mem_rd_data),
    .low_byte(low_byte), .held_byte(held_byte)
  );

  always_comb begin
    unique case (load_sel)
      SEL_TAG:  load_data = tag_byte;
      SEL_LOW:  load_data = low_byte;
      SEL_HIGH: load_data = held_byte;
      default:  load_data = lay_byte[lay_idx];
    endcase
  end

  mfs_out_stage #(.W(8)) u_out (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .load_last(load_last), .ready(hb_ready),
    .valid(hb_valid), .data(hb_data), .last(hb_last), .free(slot_free)
  );
endmodule

// File: rtl/mac_feed_seq_chk.sv
module mac_feed_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_valid,
  input logic       busy,
  input logic       mem_rd_en,
  input logic [7:0] hb_data,
  input logic       hb_valid,
  input logic       hb_ready,
  input logic       hb_last,
  input logic       done
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    hb_valid && !hb_ready |=> hb_valid && $stable(hb_data) && $stable(hb_last)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(hb_valid && hb_ready && hb_last)); // R8
  AST_LAST_ENDS_STREAM: assert property (@(posedge clk) disable iff (rst)
    hb_valid && hb_ready && hb_last |=> !hb_valid); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en && !hb_valid); // R9
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    start_valid && !busy |=> busy); // R9
endmodule

bind mac_feed_seq mac_feed_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_valid(start_valid), .busy(busy),
  .mem_rd_en(mem_rd_en), .hb_data(hb_data), .hb_valid(hb_valid),
  .hb_ready(hb_ready), .hb_last(hb_last), .done(done)
);

// File: tb/mac_feed_seq_test.sv
module mac_feed_seq_test;
  localparam int AW = 6;
  localparam int LW = 8;
  localparam int MW = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic start_valid = 1'b0;
  logic [1:0] start_op = '0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic [15:0] lay_text_lo = 16'h1234, lay_text_hi = 16'h5678;
  logic [15:0] lay_prot_lo = 16'h9abc, lay_prot_hi = 16'hdef0;
  logic busy, mem_rd_en, hb_valid, hb_last, done;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rd_data = '0;
  logic [7:0] hb_data;
  logic hb_ready = 1'b1;

  int total = 0, bad = 0, cyc = 0;
  int cap_n = 0, done_cnt = 0, done_cyc = -1, acc_cyc = -1;
  logic [7:0] cap_d [0:511];
  logic       cap_l [0:511];
  bit stall_on = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  always #2.5 clk = ~clk;

  mac_feed_seq #(.AW(AW), .LW(LW)) uut (.*);

  function automatic logic [15:0] memv(int a);
    return 16'((a * 16'h3b1d) ^ 16'hc0de);
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= memv(int'(mem_addr));

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    hb_ready <= stall_on ? (lfsr[0] & lfsr[2]) : 1'b1;
  end

  always @(posedge clk) begin
    if (hb_valid && hb_ready && cap_n < 512) begin
      cap_d[cap_n] = hb_data;
      cap_l[cap_n] = hb_last;
      cap_n = cap_n + 1;
      acc_cyc = cyc;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
    cyc = cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // R1..R9, R11 checked per operation; stall exercises R7
  task automatic run_op(int op, int addr, int len, bit stall, bit poke);
    logic [7:0] ex [0:300];
    int n = 0, t = 0, errs = 0;
    ex[n++] = 8'(op + 1);
    for (int i = 0; i < len; i++) begin
      logic [15:0] w = memv((addr + i / 2) % MW);
      ex[n++] = (i % 2 == 0) ? w[7:0] : w[15:8];
    end
    if (op == 1 || op == 2) begin
      logic [15:0] lw [4];
      lw[0] = lay_text_lo; lw[1] = lay_text_hi; lw[2] = lay_prot_lo; lw[3] = lay_prot_hi;
      for (int k = 0; k < 8; k++) ex[n++] = (k % 2 == 0) ? lw[k/2][7:0] : lw[k/2][15:8];
    end
    cap_n = 0; done_cnt = 0; stall_on = stall;
    @(negedge clk);
    start_valid = 1'b1; start_op = 2'(op); start_addr = AW'(addr); start_len = LW'(len);
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_valid = 1'b1; start_op = 2'd3; start_addr = 6'd9; start_len = 8'd3;
      @(negedge clk);
      start_valid = 1'b0;
    end
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, "R8", "done seen", t, 0);
    repeat (poke ? 12 : 4) @(negedge clk);
    chk(cap_n == n, (op == 1 || op == 2) ? "R4" : "R5", "byte count", cap_n, n);
    if (cap_n > 0) chk(cap_d[0] == ex[0], "R1", "tag byte", cap_d[0], ex[0]);
    for (int i = 1; i < n && i < cap_n; i++)
      if (cap_d[i] !== ex[i]) begin
        if (errs == 0) chk(1'b0, (i > len) ? "R4" : "R2", "stream byte", cap_d[i], ex[i]);
        errs++;
      end
    if (errs == 0) chk(1'b1, "R2", "stream bytes", 0, 0);
    errs = 0;
    for (int i = 0; i < cap_n; i++)
      if (cap_l[i] !== (i == n - 1)) errs++;
    chk(errs == 0, "R6", "last flag errors", errs, 0);
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    chk(done_cyc == acc_cyc + 1, "R8", "done timing", done_cyc, acc_cyc + 1);
    chk(busy == 1'b0, "R9", "idle after done", busy, 0);
    stall_on = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!busy && !done && !hb_valid && !mem_rd_en, "R10", "reset outputs",
        {busy, done, hb_valid, mem_rd_en}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    run_op(0, 3, 6, 1'b0, 1'b0);   // R1 R5 even length
    run_op(3, 10, 7, 1'b0, 1'b0);  // R3 odd length
    run_op(1, 5, 4, 1'b0, 1'b0);   // R4 layout append
    run_op(2, 0, 0, 1'b0, 1'b0);   // R3 zero length with layout
    run_op(3, 0, 0, 1'b0, 1'b0);   // R3 zero length, tag only
    run_op(2, 60, 9, 1'b1, 1'b0);  // R7 stalls, R2 wrap
    run_op(3, 20, 31, 1'b1, 1'b0); // R7 R11
    run_op(1, 7, 20, 1'b0, 1'b1);  // R9 start while busy
    run_op(0, 1, 255, 1'b1, 1'b0); // R2 maximum length wraps
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule